// File: doc/BRIEF.md
# PI Controller with Shift-Coefficient Filter Cascade

This block is a proportional-integral regulator for a 14-bit signed sample stream. Before the error sample reaches the controller it passes through a series chain of first-order filter stages. A small signed setting configures each stage on its own. Zero bypasses the stage. A positive value selects a low-pass response and a negative value selects a high-pass response. The magnitude of the setting is a right-shift amount, so every cutoff is a power of two and the arithmetic needs no multiplier.

The controller keeps a 32-bit signed integral that is far wider than the output. The host can overwrite the integral in any cycle, including with values well beyond what the output can show. The output is the proportional term plus a scaled-down integral, clamped to the 14-bit signed range. Setting both gains to zero freezes the integral and leaves only its scaled contribution on the output.

Top module: `pi_filter_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ctrl_o` and `ival_o` read zero, and every filter stage starts with a zero state.
- R2: Stage s (s = 0 is fed by `sig_i`, stage s+1 is fed by stage s) takes its setting from `flt_cfg[s*5 +: 5]` as a signed value. A setting of zero makes the stage pass its input unchanged with one cycle of delay.
- R3: For a positive setting k, the stage updates its state as lp ← lp + ((x − lp) >>> k), using an arithmetic shift, and outputs the new state one cycle later.
- R4: For a negative setting, the stage uses the same update with k equal to the magnitude of the setting (−16 gives 16). It outputs x − lp(new), saturated to the range −8192..8191.
- R5: While a stage is bypassed, its state follows its input, so re-enabling the stage starts from the most recent sample.
- R6: In every cycle without a host write, the integral gains ((e × `i_gain`) >>> 8), where e is the output of the last stage. The result saturates at −2^31 and 2^31−1 and never wraps.
- R7: When `ival_we` is high, `ival_wdata` replaces the integral at that edge and no accumulation happens that cycle. The written value is readable on `ival_o` in the next cycle.
- R8: At each edge `ctrl_o` becomes sat14(((e × `p_gain`) >>> 8) + (integral >>> 4)), computed from the integral held before that edge. This gives five cycles from `sig_i` to `ctrl_o` through the filter stages.
- R9: With both gains zero and the integral zero, `ctrl_o` stays zero and the integral stays unchanged for any input.
- R10: When the integral lies beyond the output range, `ctrl_o` stays pinned at 8191 or −8192 while `ival_o` keeps changing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flt_cfg | input | 20 | Four signed 5-bit stage settings, stage 0 in the lowest bits |
| sig_i | input | 14 | Signed error sample |
| p_gain | input | 16 | Signed proportional gain, 8 fractional bits |
| i_gain | input | 16 | Signed integral gain per cycle, 8 fractional bits |
| ival_we | input | 1 | Load the integral from `ival_wdata` |
| ival_wdata | input | 32 | Signed value to load into the integral |
| ival_o | output | 32 | Signed integral state |
| ctrl_o | output | 14 | Signed, saturated controller output |

## Verification
Each filter stage is one register, so a sample on `sig_i` reaches the controller four edges later and reaches `ctrl_o` at the fifth edge. A host write shows on `ival_o` after one edge and affects `ctrl_o` after two, because the output uses the integral from before the edge. The bench keeps a behavioural model that advances on the same rising edges and compares both outputs with it at every falling edge. Every one of these delays is therefore checked at the exact cycle it is due, not only in steady state. The stimulus phases cover saturating accumulation toward both 32-bit limits, a load beyond the output range with output pinning, step responses for the low-pass and high-pass stages at several shifts including the largest one, and bypass and re-enable of a stage.

// File: rtl/pif_pkg.sv
package pif_pkg;

    typedef enum logic [1:0] {
        FM_BYPASS = 2'd0,
        FM_LOW    = 2'd1,
        FM_HIGH   = 2'd2
    } flt_mode_e;

endpackage

// File: rtl/pif_filter_stage.sv
module pif_filter_stage
    import pif_pkg::*;
#(
    parameter int DW = 14,
    parameter int KW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [KW-1:0] cfg,
    input  logic signed [DW-1:0] x_i,
    output logic signed [DW-1:0] y_o
);

    localparam int DIFW = DW + 1;
    localparam logic signed [DIFW-1:0] HMAX = {2'b00, {(DW-1){1'b1}}};
    localparam logic signed [DIFW-1:0] HMIN = {2'b11, {(DW-1){1'b0}}};

    typedef struct packed {
        logic signed [DW-1:0] lp;
        logic signed [DW-1:0] y;
    } stage_st_t;

    stage_st_t st_d, st_q;

    flt_mode_e               mode;
    logic        [KW-1:0]    sh;
    logic signed [DIFW-1:0]  diff;
    logic signed [DIFW-1:0]  step;
    logic signed [DIFW-1:0]  lp_wide;
    logic signed [DW-1:0]    lp_new;
    logic signed [DIFW-1:0]  hp_wide;
    logic signed [DW-1:0]    hp_sat;

    always_comb begin
        if (cfg == '0)        mode = FM_BYPASS;
        else if (cfg[KW-1])   mode = FM_HIGH;
        else                  mode = FM_LOW;

        sh      = cfg[KW-1] ? KW'(-cfg) : KW'(cfg);
        diff    = DIFW'(x_i) - DIFW'(st_q.lp);
        step    = diff >>> sh;
        lp_wide = DIFW'(st_q.lp) + step;
        lp_new  = lp_wide[DW-1:0];
        hp_wide = DIFW'(x_i) - DIFW'(lp_new);
        if (hp_wide > HMAX)      hp_sat = HMAX[DW-1:0];
        else if (hp_wide < HMIN) hp_sat = HMIN[DW-1:0];
        else                     hp_sat = hp_wide[DW-1:0];

        st_d = st_q;
        case (mode)
            FM_LOW: begin
                st_d.lp = lp_new;
                st_d.y  = lp_new;
            end
            FM_HIGH: begin
                st_d.lp = lp_new;
                st_d.y  = hp_sat;
            end
            default: begin
                st_d.lp = x_i;
                st_d.y  = x_i;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign y_o = st_q.y;

    // R2: a bypassed stage forwards its input after one edge
    a_r2_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg == '0) |=> (y_o == $past(x_i)));

    // R3: a low-pass step never overshoots: result lies between old state and input
    a_r3_lp_between: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg[KW-1] && cfg != '0) |=>
        ((y_o >= $past(x_i) && y_o <= $past(st_q.lp)) ||
         (y_o <= $past(x_i) && y_o >= $past(st_q.lp))));

endmodule

// File: rtl/pif_filter_chain.sv
module pif_filter_chain #(
    parameter int DW   = 14,
    parameter int KW   = 5,
    parameter int NSTG = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSTG*KW-1:0]     cfg_flat,
    input  logic signed [DW-1:0]   x_i,
    output logic signed [DW-1:0]   y_o
);

    logic signed [DW-1:0] link [NSTG+1];

    assign link[0] = x_i;

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        pif_filter_stage #(.DW(DW), .KW(KW)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .cfg   ($signed(cfg_flat[s*KW +: KW])),
            .x_i   (link[s]),
            .y_o   (link[s+1])
        );
    end

    assign y_o = link[NSTG];

endmodule

// File: rtl/pif_pi_core.sv
module pif_pi_core #(
    parameter int DW = 14,
    parameter int GW = 16,
    parameter int IW = 32,
    parameter int GS = 8,
    parameter int OS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] e_i,
    input  logic signed [GW-1:0] p_gain,
    input  logic signed [GW-1:0] i_gain,
    input  logic                 ival_we,
    input  logic signed [IW-1:0] ival_wdata,
    output logic signed [IW-1:0] ival_o,
    output logic signed [DW-1:0] u_o
);

    localparam int PW = DW + GW;
    localparam int SW = IW + 1;
    localparam logic signed [SW-1:0] IMAX = {2'b00, {(IW-1){1'b1}}};
    localparam logic signed [SW-1:0] IMIN = {2'b11, {(IW-1){1'b0}}};
    localparam logic signed [SW-1:0] OMAX = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [SW-1:0] OMIN = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    typedef struct packed {
        logic signed [IW-1:0] integ;
        logic signed [DW-1:0] u;
    } core_st_t;

    core_st_t st_d, st_q;

    logic signed [PW-1:0] prod_p, prod_i, pterm, iterm;
    logic signed [SW-1:0] isum, osum;
    logic signed [IW-1:0] isat;
    logic signed [DW-1:0] osat;

    always_comb begin
        prod_p = PW'(e_i) * PW'(p_gain);
        prod_i = PW'(e_i) * PW'(i_gain);
        pterm  = prod_p >>> GS;
        iterm  = prod_i >>> GS;

        isum = SW'(st_q.integ) + SW'(iterm);
        if (isum > IMAX)      isat = IMAX[IW-1:0];
        else if (isum < IMIN) isat = IMIN[IW-1:0];
        else                  isat = isum[IW-1:0];

        osum = SW'(pterm) + SW'(st_q.integ >>> OS);
        if (osum > OMAX)      osat = OMAX[DW-1:0];
        else if (osum < OMIN) osat = OMIN[DW-1:0];
        else                  osat = osum[DW-1:0];

        st_d       = st_q;
        st_d.integ = ival_we ? ival_wdata : isat;
        st_d.u     = osat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ival_o = st_q.integ;
    assign u_o    = st_q.u;

    // R7: a host load is visible on the next cycle
    a_r7_host_load: assert property (@(posedge clk) disable iff (!rst_n)
        ival_we |=> (ival_o == $past(ival_wdata)));

    // R9: with both gains zero the integral is frozen
    a_r9_off_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!ival_we && p_gain == '0 && i_gain == '0) |=> (ival_o == $past(ival_o)));

    // R6: a non-negative integral fed a non-negative term never wraps negative
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!ival_we && !ival_o[IW-1] && !e_i[DW-1] && !i_gain[GW-1]) |=> !ival_o[IW-1]);

endmodule

// File: rtl/pi_filter_ctrl.sv
module pi_filter_ctrl #(
    parameter int DW   = 14,
    parameter int KW   = 5,
    parameter int NSTG = 4,
    parameter int GW   = 16,
    parameter int IW   = 32,
    parameter int GS   = 8,
    parameter int OS   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSTG*KW-1:0]     flt_cfg,
    input  logic signed [DW-1:0]   sig_i,
    input  logic signed [GW-1:0]   p_gain,
    input  logic signed [GW-1:0]   i_gain,
    input  logic                   ival_we,
    input  logic signed [IW-1:0]   ival_wdata,
    output logic signed [IW-1:0]   ival_o,
    output logic signed [DW-1:0]   ctrl_o
);

    logic signed [DW-1:0] err_f;

    pif_filter_chain #(.DW(DW), .KW(KW), .NSTG(NSTG)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_flat (flt_cfg),
        .x_i      (sig_i),
        .y_o      (err_f)
    );

    pif_pi_core #(.DW(DW), .GW(GW), .IW(IW), .GS(GS), .OS(OS)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .e_i        (err_f),
        .p_gain     (p_gain),
        .i_gain     (i_gain),
        .ival_we    (ival_we),
        .ival_wdata (ival_wdata),
        .ival_o     (ival_o),
        .u_o        (ctrl_o)
    );

    // R10: when the integral alone exceeds full scale and the proportional gain is zero, the output is pinned
    a_r10_pinned_high: assert property (@(posedge clk) disable iff (!rst_n)
        (p_gain == '0 && (ival_o >>> OS) > IW'(2**(DW-1) - 1)) |=> (ctrl_o == DW'(2**(DW-1) - 1)));

endmodule

// File: tb/pi_filter_ctrl_tb.sv
module pi_filter_ctrl_tb;

    localparam int DW = 14, KW = 5, NSTG = 4, GW = 16, IW = 32, GS = 8, OS = 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NSTG*KW-1:0]   flt_cfg = '0;
    logic signed [DW-1:0] sig_i = '0;
    logic signed [GW-1:0] p_gain = '0;
    logic signed [GW-1:0] i_gain = '0;
    logic                 ival_we = 1'b0;
    logic signed [IW-1:0] ival_wdata = '0;
    logic signed [IW-1:0] ival_o;
    logic signed [DW-1:0] ctrl_o;

    always #5 clk = ~clk;

    pi_filter_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .flt_cfg(flt_cfg), .sig_i(sig_i),
        .p_gain(p_gain), .i_gain(i_gain), .ival_we(ival_we),
        .ival_wdata(ival_wdata), .ival_o(ival_o), .ctrl_o(ctrl_o)
    );

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    longint m_lp [NSTG];
    longint m_y  [NSTG];
    longint m_int, m_out;

    function automatic longint clampv(longint v, longint lo, longint hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic longint cfg_of(int s);
        logic [KW-1:0] raw;
        raw = flt_cfg[s*KW +: KW];
        return longint'($signed(raw));
    endfunction

    // behavioural reference, advances on the same edges as the design
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NSTG; s++) begin m_lp[s] = 0; m_y[s] = 0; end
            m_int = 0; m_out = 0;
        end else begin
            longint e, pt, it, nxt, c, k, x;
            e  = m_y[NSTG-1];
            pt = (e * longint'(p_gain)) >>> GS;
            it = (e * longint'(i_gain)) >>> GS;
            m_out = clampv(pt + (m_int >>> OS), -8192, 8191);
            nxt = ival_we ? longint'(ival_wdata) : clampv(m_int + it, -64'sd2147483648, 64'sd2147483647);
            m_int = nxt;
            for (int s = NSTG-1; s >= 0; s--) begin
                x = (s == 0) ? longint'(sig_i) : m_y[s-1];
                c = cfg_of(s);
                if (c == 0) begin
                    m_lp[s] = x; m_y[s] = x;
                end else begin
                    k = (c < 0) ? -c : c;
                    m_lp[s] = m_lp[s] + ((x - m_lp[s]) >>> k);
                    m_y[s]  = (c > 0) ? m_lp[s] : clampv(x - m_lp[s], -8192, 8191);
                end
            end
        end
    end

    task automatic chk(string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("ctrl_o", longint'(ctrl_o), m_out);
            chk("ival_o", longint'(ival_o), m_int);
        end
    endtask

    task automatic set_cfg(int s, int v);
        flt_cfg[s*KW +: KW] = KW'(v);
    endtask

    task automatic load(longint v);
        ival_wdata = IW'(v);
        ival_we = 1'b1;
        run(1);
        ival_we = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        longint prev;
        // R1: reset state, also with nonzero inputs present
        sig_i = 14'sd1000; p_gain = 16'sd256;
        run(3);
        @(negedge clk); rst_n = 1'b1;
        run(1);
        chk("R1 ctrl_o zero after reset", longint'(ctrl_o), 0);

        // R2 and R8: all stages bypassed, proportional path only, several patterns
        tag = "R2";
        for (int i = 0; i < 24; i++) begin
            sig_i = DW'(i * 611 - 7000);
            run(1);
        end
        tag = "R8";
        p_gain = -16'sd700;
        for (int i = 0; i < 16; i++) begin
            sig_i = (i % 2 == 0) ? 14'sd3000 : -14'sd50;
            run(1);
        end
        // five-cycle latency from sig_i to ctrl_o with unit gain
        p_gain = 16'sd256; sig_i = 14'sd0; run(8);
        sig_i = 14'sd1234; run(4);
        chk("R8 no change before fifth edge", longint'(ctrl_o), 0);
        run(1);
        chk("R8 value at fifth edge", longint'(ctrl_o), 1234);

        // R3: low-pass stage 0, several shifts
        tag = "R3";
        set_cfg(0, 2); sig_i = 14'sd4000; run(20);
        set_cfg(0, 5); sig_i = -14'sd5000; run(40);
        set_cfg(0, 0);

        // R4: high-pass stage 1, including the largest shift
        tag = "R4";
        sig_i = 14'sd0; run(6);
        set_cfg(1, -3); sig_i = 14'sd8000; run(20);
        sig_i = -14'sd8192; run(20);
        set_cfg(1, -16); sig_i = 14'sd8191; run(10);
        set_cfg(1, 0);

        // R5: bypass tracks the input, re-enable starts from the latest sample
        tag = "R5";
        set_cfg(2, 4); sig_i = 14'sd2000; run(10);
        set_cfg(2, 0); sig_i = -14'sd3000; run(6);
        set_cfg(2, 4); run(6);
        chk("R5 re-enabled stage holds latest sample", longint'(ctrl_o), -3000);
        set_cfg(2, 0);

        // mixed cascade
        tag = "R3";
        set_cfg(0, 1); set_cfg(1, -2); set_cfg(2, 3); set_cfg(3, -1);
        for (int i = 0; i < 40; i++) begin
            sig_i = DW'((i * 2741) % 16384 - 8192);
            run(1);
        end
        flt_cfg = '0;

        // R6: integrate to both 32-bit limits
        tag = "R6";
        p_gain = '0; sig_i = 14'sd8191; i_gain = 16'sd32767; run(2200);
        chk("R6 positive limit", longint'(ival_o), 64'sd2147483647);
        sig_i = -14'sd8192; run(4400);
        chk("R6 negative limit", longint'(ival_o), -64'sd2147483648);

        // R7: host load overrides accumulation and is readable next cycle
        tag = "R7";
        sig_i = 14'sd100; i_gain = 16'sd512;
        load(131000);
        chk("R7 loaded value", longint'(ival_o), 131000);
        run(5);
        load(-524288);
        run(3);

        // R10: integral beyond range, output pinned while integral moves
        tag = "R10";
        sig_i = 14'sd1000; i_gain = -16'sd256; p_gain = '0;
        load(524288);
        run(6);
        prev = longint'(ival_o);
        run(10);
        chk("R10 pinned high", longint'(ctrl_o), 8191);
        chk("R10 integral still changing", longint'(ival_o != IW'(prev)), 1);
        load(-600000); i_gain = 16'sd256; run(10);
        chk("R10 pinned low", longint'(ctrl_o), -8192);

        // R9: gains zero and integral zero keep the output at zero
        tag = "R9";
        p_gain = '0; i_gain = '0;
        load(0);
        for (int i = 0; i < 20; i++) begin
            sig_i = DW'(i * 977 - 9000);
            run(1);
        end
        chk("R9 output zero", longint'(ctrl_o), 0);
        chk("R9 integral unchanged", longint'(ival_o), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule